// File: doc/BRIEF.md
# Dual Parallel Load Unit

This unit carries out the parallel-load extension byte of a 16-bit DSP instruction word. Each accepted byte makes two reads from data memory. The two words go into 16-bit halves of the auxiliary registers AX0 and AX1. The unit then works out new values for the two address pointers it used. It does not own the register file. It takes the pointer (AR) and index (IX) registers as flat input buses, and it returns its results through dedicated write ports that are active in one commit cycle.

The instruction byte enters on a valid/ready handshake. `ins_ready` is high only while the unit is idle. A byte is taken on a clock edge where both `ins_valid` and `ins_ready` are high. While the unit is busy, the producer must hold its byte and `ins_valid` until `ins_ready` returns. The AR and IX values are sampled on that same edge, so later changes to those buses do not affect the instruction in flight. The memory port is a plain read strobe with a fixed one-cycle latency. Each data word sits on `mem_rdata` in the cycle after its address was presented.

A matching byte gives a first read in the cycle after acceptance and a second read in the cycle after that. All writes are then presented together, along with `done`, in the third cycle. When the low two bits of the byte are 11, the same byte is decoded in a different way: it becomes a high/low load of a single AX register. This form has priority over the normal form.

Top module: `dual_load_unit`

## Requirements
- R1: After reset `ins_ready` is 1 and `done` is 0. `ins_ready` is 0 from the cycle after acceptance until `done`, and it is 1 again in the cycle after `done`.
- R2: A byte whose bits 7:6 are not 11 is a no-op. `done` pulses in the cycle after acceptance, with no memory read and no write enable.
- R3: Normal form (bits 7:6 = 11, bits 1:0 = s with s not 3). The first word is read from AR[s] and written into AX0: the high half if bit 5 is 1, otherwise the low half. The second word is read from AR3 and written into AX1: the high half if bit 4 is 1, otherwise the low half.
- R4: Re-decoded form (bits 7:6 = 11, bits 1:0 = 11). Bit 5 selects the first pointer, AR0 or AR1, and bit 4 selects one register AXr (0 = AX0, 1 = AX1). AXr high is loaded from that pointer and AXr low from AR3.
- R5: If the first address and AR3 agree in bits 15:10, the second read uses the first address. Both destinations then receive the same word.
- R6: With bits 3:2 = 00, the first pointer and AR3 are each written back incremented by one.
- R7: Bit 2 = 1 makes the first pointer advance by the signed value of its own IX register instead of by one.
- R8: Bit 3 = 1 makes AR3 advance by the signed value of IX3 instead of by one.
- R9: All pointer arithmetic wraps modulo 2^16.
- R10: Reads and pointer updates use the AR/IX values sampled at acceptance. No write enable is active before `done`, which comes three cycles after acceptance for a matching byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Extension byte valid |
| ins_ready | output | 1 | Unit idle, byte can be taken |
| ins_byte | input | 8 | Extension byte |
| ar_flat | input | 64 | AR0..AR3, AR0 in bits 15:0 |
| ix_flat | input | 64 | IX0..IX3, IX0 in bits 15:0 |
| mem_rd_en | output | 1 | Data memory read strobe |
| mem_addr | output | 16 | Data memory read address |
| mem_rdata | input | 16 | Read data, one cycle after the strobe |
| axw_a_en | output | 1 | First AX half write enable |
| axw_a_reg | output | 1 | First write target: 0 = AX0, 1 = AX1 |
| axw_a_hi | output | 1 | First write half: 1 = high |
| axw_a_data | output | 16 | First write data |
| axw_b_en | output | 1 | Second AX half write enable |
| axw_b_reg | output | 1 | Second write target register |
| axw_b_hi | output | 1 | Second write half: 1 = high |
| axw_b_data | output | 16 | Second write data |
| arw_src_en | output | 1 | First pointer write enable |
| arw_src_idx | output | 2 | First pointer index |
| arw_src_data | output | 16 | First pointer new value |
| arw_ar3_en | output | 1 | AR3 write enable |
| arw_ar3_data | output | 16 | AR3 new value |
| done | output | 1 | Commit cycle of an accepted byte |

## Verification
The AX data writes and both pointer post-modifications fall in the same commit cycle. In that cycle the second data word also arrives straight from memory. Directed tests sample every write port at the `done` cycle and compare the values against a model built from the requirements. One test changes the AR/IX buses right after acceptance, to show that the data written and the new pointer values both come from the sampled state. The same-area redirect is provoked by placing AR3 inside or outside the first pointer's 1K-word area. Each memory location returns a distinct word, so a wrong second address shows up directly in the data.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int NUM_PTR  = 4;
  localparam int PTR_IDXW = 2;
  localparam logic [PTR_IDXW-1:0] PTR_LAST = 2'd3;

  typedef struct packed {
    logic                valid;
    logic                redec;
    logic [PTR_IDXW-1:0] src;
    logic                a_reg;
    logic                a_hi;
    logic                b_reg;
    logic                b_hi;
    logic                ix_src;
    logic                ix_ar3;
  } ldu_dec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDA  = 2'd1,
    ST_RDB  = 2'd2,
    ST_FIN  = 2'd3
  } ldu_state_e;
endpackage

// File: rtl/ldu_decode.sv
module ldu_decode
  import ldu_pkg::*;
(
  input  logic [7:0] byte_in,
  output ldu_dec_t   dec
);
  logic sel_hit;
  logic pair_form;

  // pair form (low bits 11) wins over the normal form
  assign sel_hit   = (byte_in[7:6] == 2'b11);
  assign pair_form = (byte_in[1:0] == PTR_LAST);

  always_comb begin
    dec        = '0;
    dec.valid  = sel_hit;
    dec.redec  = sel_hit & pair_form;
    dec.ix_src = byte_in[2];
    dec.ix_ar3 = byte_in[3];
    if (pair_form) begin
      dec.src   = {1'b0, byte_in[5]};
      dec.a_reg = byte_in[4];
      dec.a_hi  = 1'b1;
      dec.b_reg = byte_in[4];
      dec.b_hi  = 1'b0;
    end else begin
      dec.src   = byte_in[1:0];
      dec.a_reg = 1'b0;
      dec.a_hi  = byte_in[5];
      dec.b_reg = 1'b1;
      dec.b_hi  = byte_in[4];
    end
  end
endmodule

// File: rtl/ldu_agen.sv
module ldu_agen #(
  parameter int AW       = 16,
  parameter int AREA_LSB = 10
) (
  input  logic [AW-1:0] src_ptr,
  input  logic [AW-1:0] src_ix,
  input  logic [AW-1:0] ar3_ptr,
  input  logic [AW-1:0] ar3_ix,
  input  logic          use_src_ix,
  input  logic          use_ar3_ix,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [AW-1:0] src_next,
  output logic [AW-1:0] ar3_next
);
  localparam int AREA_W = AW - AREA_LSB;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0]     diff;
  logic [AREA_W-1:0] area_diff;
  logic              same_area;

  assign diff      = src_ptr ^ ar3_ptr;
  assign area_diff = diff[AW-1:AREA_LSB];
  assign same_area = (area_diff == '0);

  assign addr_a   = src_ptr;
  assign addr_b   = same_area ? src_ptr : ar3_ptr;
  // two's complement add: signed step and 2^AW wrap come for free
  assign src_next = src_ptr + (use_src_ix ? src_ix : ONE);
  assign ar3_next = ar3_ptr + (use_ar3_ix ? ar3_ix : ONE);
endmodule

// File: rtl/dual_load_unit.sv
module dual_load_unit
  import ldu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int AREA_LSB = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_valid,
  output logic                  ins_ready,
  input  logic [7:0]            ins_byte,
  input  logic [NUM_PTR*AW-1:0] ar_flat,
  input  logic [NUM_PTR*AW-1:0] ix_flat,
  output logic                  mem_rd_en,
  output logic [AW-1:0]         mem_addr,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  axw_a_en,
  output logic                  axw_a_reg,
  output logic                  axw_a_hi,
  output logic [DW-1:0]         axw_a_data,
  output logic                  axw_b_en,
  output logic                  axw_b_reg,
  output logic                  axw_b_hi,
  output logic [DW-1:0]         axw_b_data,
  output logic                  arw_src_en,
  output logic [PTR_IDXW-1:0]   arw_src_idx,
  output logic [AW-1:0]         arw_src_data,
  output logic                  arw_ar3_en,
  output logic [AW-1:0]         arw_ar3_data,
  output logic                  done
);
  logic [AW-1:0] ar_v [NUM_PTR];
  logic [AW-1:0] ix_v [NUM_PTR];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PTR; gi++) begin : g_unpack
      assign ar_v[gi] = ar_flat[gi*AW +: AW];
      assign ix_v[gi] = ix_flat[gi*AW +: AW];
    end
  endgenerate

  ldu_dec_t dec_c, dec_q;
  logic [AW-1:0] addr_a_c, addr_b_c, src_next_c, ar3_next_c;
  logic [AW-1:0] addr_a_q, addr_b_q, src_next_q, ar3_next_q;
  logic [DW-1:0] data_a_q;
  ldu_state_e    state;
  logic          accept;

  ldu_decode u_dec (
    .byte_in (ins_byte),
    .dec     (dec_c)
  );

  ldu_agen #(.AW(AW), .AREA_LSB(AREA_LSB)) u_agen (
    .src_ptr    (ar_v[dec_c.src]),
    .src_ix     (ix_v[dec_c.src]),
    .ar3_ptr    (ar_v[PTR_LAST]),
    .ar3_ix     (ix_v[PTR_LAST]),
    .use_src_ix (dec_c.ix_src),
    .use_ar3_ix (dec_c.ix_ar3),
    .addr_a     (addr_a_c),
    .addr_b     (addr_b_c),
    .src_next   (src_next_c),
    .ar3_next   (ar3_next_c)
  );

  assign ins_ready = (state == ST_IDLE);
  assign accept    = ins_valid & ins_ready;

  // sequencer: snapshot on accept, two reads, one commit cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) state <= dec_c.valid ? ST_RDA : ST_FIN;
        ST_RDA:  state <= ST_RDB;
        ST_RDB:  state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q      <= '0;
      addr_a_q   <= '0;
      addr_b_q   <= '0;
      src_next_q <= '0;
      ar3_next_q <= '0;
      data_a_q   <= '0;
    end else begin
      if (accept) begin
        dec_q      <= dec_c;
        addr_a_q   <= addr_a_c;
        addr_b_q   <= addr_b_c;
        src_next_q <= src_next_c;
        ar3_next_q <= ar3_next_c;
      end
      if (state == ST_RDB) data_a_q <= mem_rdata;
    end
  end

  logic commit;
  assign commit = (state == ST_FIN) & dec_q.valid;

  assign mem_rd_en = (state == ST_RDA) | (state == ST_RDB);
  assign mem_addr  = (state == ST_RDB) ? addr_b_q : addr_a_q;

  assign done         = (state == ST_FIN);
  assign axw_a_en     = commit;
  assign axw_a_reg    = dec_q.a_reg;
  assign axw_a_hi     = dec_q.a_hi;
  assign axw_a_data   = data_a_q;
  assign axw_b_en     = commit;
  assign axw_b_reg    = dec_q.b_reg;
  assign axw_b_hi     = dec_q.b_hi;
  assign axw_b_data   = mem_rdata;
  assign arw_src_en   = commit;
  assign arw_src_idx  = dec_q.src;
  assign arw_src_data = src_next_q;
  assign arw_ar3_en   = commit;
  assign arw_ar3_data = ar3_next_q;
endmodule

// File: rtl/ldu_checker.sv
module ldu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ins_valid,
  input logic       ins_ready,
  input logic       mem_rd_en,
  input logic       axw_a_en,
  input logic       axw_b_en,
  input logic       arw_src_en,
  input logic [1:0] arw_src_idx,
  input logic       arw_ar3_en,
  input logic       done
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> !ins_ready);

  assert_ready_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ins_ready);

  assert_idle_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !mem_rd_en);

  assert_src_not_ar3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arw_src_en |-> (arw_src_idx != 2'd3));

  assert_commit_in_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (axw_a_en || axw_b_en || arw_src_en || arw_ar3_en) |-> done);

  assert_commit_together_R10: assert property (@(posedge clk) disable iff (!rst_n)
    axw_a_en |-> (axw_b_en && arw_src_en && arw_ar3_en));

  assert_data_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    axw_b_en |-> $past(mem_rd_en));
endmodule

bind dual_load_unit ldu_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ins_valid   (ins_valid),
  .ins_ready   (ins_ready),
  .mem_rd_en   (mem_rd_en),
  .axw_a_en    (axw_a_en),
  .axw_b_en    (axw_b_en),
  .arw_src_en  (arw_src_en),
  .arw_src_idx (arw_src_idx),
  .arw_ar3_en  (arw_ar3_en),
  .done        (done)
);

// File: tb/dual_load_unit_tb.sv
module dual_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [7:0]  ins_byte = 8'h00;
  logic [63:0] ar_flat = '0;
  logic [63:0] ix_flat = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        axw_a_en, axw_a_reg, axw_a_hi;
  logic [15:0] axw_a_data;
  logic        axw_b_en, axw_b_reg, axw_b_hi;
  logic [15:0] axw_b_data;
  logic        arw_src_en;
  logic [1:0]  arw_src_idx;
  logic [15:0] arw_src_data;
  logic        arw_ar3_en;
  logic [15:0] arw_ar3_data;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  dual_load_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_byte(ins_byte), .ar_flat(ar_flat), .ix_flat(ix_flat),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .axw_a_en(axw_a_en), .axw_a_reg(axw_a_reg), .axw_a_hi(axw_a_hi), .axw_a_data(axw_a_data),
    .axw_b_en(axw_b_en), .axw_b_reg(axw_b_reg), .axw_b_hi(axw_b_hi), .axw_b_data(axw_b_data),
    .arw_src_en(arw_src_en), .arw_src_idx(arw_src_idx), .arw_src_data(arw_src_data),
    .arw_ar3_en(arw_ar3_en), .arw_ar3_data(arw_ar3_data), .done(done)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC35A;
  endfunction

  // memory model with one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rdata <= memf(mem_addr);
  end

  logic [15:0] ar [4];
  logic [15:0] ix [4];

  task automatic load_regs();
    for (int i = 0; i < 4; i++) begin
      ar_flat[i*16 +: 16] = ar[i];
      ix_flat[i*16 +: 16] = ix[i];
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // apply one byte, compare all commit ports with a requirement model
  task automatic apply(input logic [7:0] b, input string req, input bit scramble);
    logic [15:0] sar [4];
    logic [15:0] six [4];
    bit match, pair, saw_rd, early_we;
    logic [1:0] si;
    logic [15:0] ea, eb, esrc, ear3;
    logic ea_reg, ea_hi, eb_reg, eb_hi;
    int n;
    for (int i = 0; i < 4; i++) begin sar[i] = ar[i]; six[i] = ix[i]; end
    match  = (b[7:6] == 2'b11);
    pair   = (b[1:0] == 2'b11);
    si     = pair ? {1'b0, b[5]} : b[1:0];
    ea     = sar[si];
    eb     = (ea[15:10] == sar[3][15:10]) ? ea : sar[3];
    ea_reg = pair ? b[4] : 1'b0;
    ea_hi  = pair ? 1'b1 : b[5];
    eb_reg = pair ? b[4] : 1'b1;
    eb_hi  = pair ? 1'b0 : b[4];
    esrc   = sar[si] + (b[2] ? six[si] : 16'd1);
    ear3   = sar[3] + (b[3] ? six[3] : 16'd1);

    @(negedge clk);
    ins_byte  = b;
    ins_valid = 1'b1;
    n = 0; saw_rd = 0; early_we = 0;
    do begin
      @(negedge clk);
      ins_valid = 1'b0;
      n++;
      if (scramble) begin
        for (int i = 0; i < 4; i++) begin ar[i] = ~ar[i]; ix[i] = ix[i] + 16'h0111; end
        load_regs();
      end
      if (mem_rd_en) saw_rd = 1;
      if (!done && (axw_a_en || axw_b_en || arw_src_en || arw_ar3_en)) early_we = 1;
      if (n == 1) chk(ins_ready == 1'b0, "R1", "ready while busy", ins_ready, 0);
    end while (!done && n < 20);

    chk(done == 1'b1, req, "done seen", done, 1);
    chk(early_we == 0, "R10", "write before done", early_we, 0);
    if (!match) begin
      chk(n == 1, "R2", "noop latency", n, 1);
      chk(saw_rd == 0, "R2", "noop read", saw_rd, 0);
      chk({axw_a_en, axw_b_en, arw_src_en, arw_ar3_en} == 4'b0, "R2", "noop writes",
          {axw_a_en, axw_b_en, arw_src_en, arw_ar3_en}, 0);
    end else begin
      chk(n == 3, "R10", "commit latency", n, 3);
      chk(axw_a_en && axw_b_en && arw_src_en && arw_ar3_en, req, "enables",
          {axw_a_en, axw_b_en, arw_src_en, arw_ar3_en}, 15);
      chk({axw_a_reg, axw_a_hi} == {ea_reg, ea_hi}, req, "first dest",
          {axw_a_reg, axw_a_hi}, {ea_reg, ea_hi});
      chk({axw_b_reg, axw_b_hi} == {eb_reg, eb_hi}, req, "second dest",
          {axw_b_reg, axw_b_hi}, {eb_reg, eb_hi});
      chk(axw_a_data == memf(ea), req, "first data", axw_a_data, memf(ea));
      chk(axw_b_data == memf(eb), req, "second data", axw_b_data, memf(eb));
      chk(arw_src_idx == si, req, "src index", arw_src_idx, si);
      chk(arw_src_data == esrc, req, "src update", arw_src_data, esrc);
      chk(arw_ar3_data == ear3, req, "ar3 update", arw_ar3_data, ear3);
    end
    @(negedge clk);
    chk(ins_ready == 1'b1, "R1", "ready after done", ins_ready, 1);
  endtask

  task automatic set_regs(input logic [15:0] a0, input logic [15:0] a1,
                          input logic [15:0] a2, input logic [15:0] a3,
                          input logic [15:0] i0, input logic [15:0] i1,
                          input logic [15:0] i2, input logic [15:0] i3);
    ar[0] = a0; ar[1] = a1; ar[2] = a2; ar[3] = a3;
    ix[0] = i0; ix[1] = i1; ix[2] = i2; ix[3] = i3;
    load_regs();
  endtask

  task automatic t_reset();
    chk(ins_ready == 1'b1, "R1", "reset ready", ins_ready, 1);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(mem_rd_en == 1'b0, "R1", "reset read", mem_rd_en, 0);
  endtask

  task automatic t_normal();   // R3 R6: areas apart, every half choice
    set_regs(16'h0100, 16'h0900, 16'h1100, 16'h8000, 16'h3, 16'h5, 16'h7, 16'h9);
    apply(8'hC0, "R3", 0);
    apply(8'hF1, "R3", 0);
    apply(8'hE2, "R6", 0);
    apply(8'hD0, "R6", 0);
  endtask

  task automatic t_pair();     // R4
    set_regs(16'h0200, 16'h2400, 16'h0000, 16'h9000, 16'h2, 16'h4, 16'h0, 16'h6);
    apply(8'hC3, "R4", 0);
    apply(8'hF3, "R4", 0);
    apply(8'hDF, "R4", 0);
  endtask

  task automatic t_same_area(); // R5
    set_regs(16'h8010, 16'h0000, 16'h83F0, 16'h83FF, 16'h1, 16'h1, 16'h1, 16'h1);
    apply(8'hC0, "R5", 0);
    apply(8'hE2, "R5", 0);
    apply(8'hE3, "R5", 0);
    set_regs(16'h83FF, 16'h0, 16'h0, 16'h8400, 16'h0, 16'h0, 16'h0, 16'h0);
    apply(8'hC0, "R5", 0);
  endtask

  task automatic t_indexed();  // R7 R8 with negative steps
    set_regs(16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'hFFF0, 16'h0020, 16'h0005, 16'hFF00);
    apply(8'hC5, "R7", 0);
    apply(8'hC8, "R8", 0);
    apply(8'hCE, "R7", 0);
    apply(8'hCF, "R8", 0);
  endtask

  task automatic t_wrap();     // R9
    set_regs(16'hFFFF, 16'h0003, 16'h0, 16'hFFFF, 16'h0, 16'hFFFC, 16'h0, 16'h0002);
    apply(8'hC0, "R9", 0);
    apply(8'hCD, "R9", 0);
  endtask

  task automatic t_noop();     // R2
    set_regs(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h1, 16'h1, 16'h1, 16'h1);
    apply(8'h00, "R2", 0);
    apply(8'h83, "R2", 0);
    apply(8'h7F, "R2", 0);
  endtask

  task automatic t_deferred(); // R10: buses change right after accept
    set_regs(16'h0400, 16'h0C00, 16'h1C00, 16'h5000, 16'h10, 16'h20, 16'h30, 16'h40);
    apply(8'hC6, "R10", 1);
    set_regs(16'h0400, 16'h0C00, 16'h1C00, 16'h5000, 16'h10, 16'h20, 16'h30, 16'h40);
    apply(8'hEB, "R10", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_pair();
    t_same_area();
    t_indexed();
    t_wrap();
    t_noop();
    t_deferred();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule